// File: doc/BRIEF.md
# Integer Execution Unit with Signed-Overflow Trap

This block is the integer execution stage of a simple load/store processor core. It is purely combinational. It takes two operands, a constant shift count and an operation code, and in the same cycle it returns a result word and one exception flag. The flag marks two's-complement overflow on the trapping add and subtract operations.

The unit covers wrapping and trapping add and subtract, the four bitwise operations, left and right shifts by a constant or by a register value, signed and unsigned less-than tests, and placing an immediate in the upper half of the word. The caller sign- or zero-extends immediates before they reach the operand pins. Add-immediate uses the trapping add code with an extended operand. The result is always driven, even when the flag is set. Blocking the register write on overflow is the caller's job.

There is no stream handshake. A combinational stage has no storage to hold data back, so no valid/ready pair is provided: the outputs follow the inputs in the same cycle.

Top module: `int_exec_alu`

## Requirements
- R1: Op code 0 (trapping add) gives result = (A + B) modulo 2^WIDTH. It raises `ovf_o` exactly when A and B have the same sign bit and the result's sign bit differs from it.
- R2: Op code 2 (trapping subtract) gives result = (A - B) modulo 2^WIDTH. It raises `ovf_o` exactly when the signed difference lies outside the signed WIDTH-bit range. The result is still driven when the flag is high.
- R3: `ovf_o` stays low for every op code other than 0 and 2. This includes op code 1 (wrapping add) and op code 3 (wrapping subtract), which give the same result values as codes 0 and 2.
- R4: Op codes 4, 5, 6 and 7 give A AND B, A OR B, A XOR B and NOT(A OR B), bit by bit.
- R5: Op codes 8, 9 and 10 shift A by `shamt_i`: left with zero fill, right with zero fill, and right with copies of A's top bit.
- R6: Op codes 11, 12 and 13 perform the same three shifts as R5. The count is taken from the low log2(WIDTH) bits of B, and the upper bits of B have no effect on the result.
- R7: Op code 14 gives 1 when A < B as signed numbers and 0 otherwise. All other result bits are zero.
- R8: Op code 15 gives 1 when A < B as unsigned numbers and 0 otherwise.
- R9: Op code 16 gives the low WIDTH/2 bits of B in the upper half of the result, with the lower half zero.
- R10: Op codes 17 to 31 give a zero result and a low flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand (shift source) |
| b_i | input | WIDTH | Second operand, variable shift count, or upper-half immediate |
| shamt_i | input | log2(WIDTH) | Constant shift count |
| op_i | input | 5 | Operation code |
| result_o | output | WIDTH | Result word |
| ovf_o | output | 1 | Signed overflow on trapping add/subtract |

## Verification
The bench builds the unit with WIDTH = 8, so the shift count is 3 bits wide. At that size every pair of operands can be applied to every defined op code. Every overflow boundary, every signed/unsigned ordering and every shift count is covered, including variable counts with junk in B's upper bits. Unused op codes are swept over all A values with a varied B.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADDU = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBU = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_NOR  = 5'd7,
    OP_SLL  = 5'd8,
    OP_SRL  = 5'd9,
    OP_SRA  = 5'd10,
    OP_SLLV = 5'd11,
    OP_SRLV = 5'd12,
    OP_SRAV = 5'd13,
    OP_SLT  = 5'd14,
    OP_SLTU = 5'd15,
    OP_LUI  = 5'd16
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
// Shared adder: add, subtract and the two magnitude compares.
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o,
  output logic             lt_signed_o,
  output logic             lt_unsigned_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    full  = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
  end

  assign sum_o         = full[MSB:0];
  // operands agree in sign, sum disagrees
  assign ovf_o         = (a_i[MSB] == b_eff[MSB]) && (full[MSB] != a_i[MSB]);
  assign lt_signed_o   = full[MSB] ^ ovf_o;
  assign lt_unsigned_o = ~full[WIDTH];
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       sel_i,   // 0 and, 1 or, 2 xor, 3 nor
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      2'd0:    res_o = a_i & b_i;
      2'd1:    res_o = a_i | b_i;
      2'd2:    res_o = a_i ^ b_i;
      default: res_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
// Right barrel shifter; left shifts reuse it through bit reversal.
module alu_shift #(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic [SHW-1:0]   amt_i,
  input  logic             left_i,
  input  logic             arith_i,
  output logic [WIDTH-1:0] res_o
);
  logic [WIDTH-1:0] val_rev;
  logic [WIDTH-1:0] stage [SHW+1];
  logic [WIDTH-1:0] out_rev;
  logic             fill;

  assign fill = arith_i & ~left_i & val_i[WIDTH-1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign val_rev[i] = val_i[WIDTH-1-i];
    assign out_rev[i] = stage[SHW][WIDTH-1-i];
  end

  assign stage[0] = left_i ? val_rev : val_i;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt_i[k]
                        ? {{STEP{fill}}, stage[k][WIDTH-1:STEP]}
                        : stage[k];
  end

  assign res_o = left_i ? out_rev : stage[SHW];
endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH),
  localparam int HALF = WIDTH / 2
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [SHW-1:0]   shamt_i,
  input  logic [4:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             ovf_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // adder control
  logic             do_sub;
  logic [WIDTH-1:0] sum;
  logic             add_ovf, lt_s, lt_u;

  assign do_sub = (op == OP_SUB) || (op == OP_SUBU) ||
                  (op == OP_SLT) || (op == OP_SLTU);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i           (a_i),
    .b_i           (b_i),
    .sub_i         (do_sub),
    .sum_o         (sum),
    .ovf_o         (add_ovf),
    .lt_signed_o   (lt_s),
    .lt_unsigned_o (lt_u)
  );

  logic [WIDTH-1:0] logic_res;
  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (op_i[1:0]),
    .res_o (logic_res)
  );

  // shifter control: variable shifts take the count from B
  logic             sh_var, sh_left, sh_arith;
  logic [SHW-1:0]   sh_amt;
  logic [WIDTH-1:0] shift_res;

  assign sh_var   = (op == OP_SLLV) || (op == OP_SRLV) || (op == OP_SRAV);
  assign sh_left  = (op == OP_SLL)  || (op == OP_SLLV);
  assign sh_arith = (op == OP_SRA)  || (op == OP_SRAV);
  assign sh_amt   = sh_var ? b_i[SHW-1:0] : shamt_i;

  alu_shift #(.WIDTH(WIDTH)) u_shift (
    .val_i   (a_i),
    .amt_i   (sh_amt),
    .left_i  (sh_left),
    .arith_i (sh_arith),
    .res_o   (shift_res)
  );

  always_comb begin
    result_o = '0;
    case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU:       result_o = sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR:          result_o = logic_res;
      OP_SLL, OP_SRL, OP_SRA,
      OP_SLLV, OP_SRLV, OP_SRAV:              result_o = shift_res;
      OP_SLT:  result_o = {{(WIDTH-1){1'b0}}, lt_s};
      OP_SLTU: result_o = {{(WIDTH-1){1'b0}}, lt_u};
      OP_LUI:  result_o = {b_i[HALF-1:0], {(WIDTH-HALF){1'b0}}};
      default: result_o = '0;
    endcase
  end

  // only the trapping forms report overflow; the result is driven regardless
  assign ovf_o = add_ovf && ((op == OP_ADD) || (op == OP_SUB));
endmodule

// File: rtl/int_exec_alu_checks.sv
module int_exec_alu_checks
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH),
  localparam int HALF = WIDTH / 2
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [SHW-1:0]   shamt_i,
  input logic [4:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    if (op_i != 5'd0 && op_i != 5'd2)
      a_r3_no_overflow: assert (ovf_o == 1'b0)
        else $error("flag raised on non-trapping op %0d", op_i);

    if (op_i == 5'd0 && ovf_o)
      a_r1_overflow_sign: assert ((a_i[MSB] == b_i[MSB]) && (result_o[MSB] != a_i[MSB]))
        else $error("add overflow flag without sign conflict");

    if (op_i == 5'd2 && ovf_o)
      a_r2_overflow_sign: assert ((a_i[MSB] != b_i[MSB]) && (result_o[MSB] != a_i[MSB]))
        else $error("sub overflow flag without sign conflict");

    if (op_i == 5'd7)
      a_r4_nor: assert (result_o == ~(a_i | b_i))
        else $error("nor mismatch");

    if (op_i == 5'd14 || op_i == 5'd15)
      a_r7_bool_result: assert (result_o[MSB:1] == '0)
        else $error("set-less-than result not 0 or 1");

    if (op_i == 5'd16)
      a_r9_lower_half_zero: assert (result_o[HALF-1:0] == '0)
        else $error("upper-immediate low half not zero");

    if (op_i > 5'd16)
      a_r10_unused_zero: assert (result_o == '0)
        else $error("unused op produced non-zero result");
  end
endmodule

bind int_exec_alu int_exec_alu_checks #(.WIDTH(WIDTH)) u_checks (
  .a_i      (a_i),
  .b_i      (b_i),
  .shamt_i  (shamt_i),
  .op_i     (op_i),
  .result_o (result_o),
  .ovf_o    (ovf_o)
);

// File: tb/test_int_exec_alu.sv
`timescale 1ns/1ps
module test_int_exec_alu;
  localparam int W   = 8;
  localparam int SHW = 3;
  localparam int HW  = W / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [W-1:0]   a, b, res;
  logic [SHW-1:0] shamt;
  logic [4:0]     op;
  logic           ovf;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  int_exec_alu #(.WIDTH(W)) i_int_exec_alu (
    .a_i(a), .b_i(b), .shamt_i(shamt), .op_i(op),
    .result_o(res), .ovf_o(ovf)
  );

  task automatic check(input string req, input logic [W-1:0] er, input logic eo);
    compared++;
    if (res !== er || ovf !== eo) begin
      mismatched++;
      if (mismatched <= 20)
        $display("FAIL %s op=%0d a=%h b=%h sh=%0d: result %h ovf %b, expected %h ovf %b",
                 req, op, a, b, shamt, res, ovf, er, eo);
    end
  endtask

  function automatic logic [W-1:0] shr(input logic [W-1:0] v, input int s, input bit ar);
    longint t;
    if (ar) t = longint'($signed(v)); else t = longint'(v);
    t = t >>> s;
    return t[W-1:0];
  endfunction

  task automatic apply_and_check(input int o, input logic [W-1:0] av,
                                 input logic [W-1:0] bv, input int sh);
    longint sa, sb, s;
    logic [W-1:0] er;
    logic eo;
    string rq;
    op = o[4:0]; a = av; b = bv; shamt = sh[SHW-1:0];
    #2;
    sa = longint'($signed(av));
    sb = longint'($signed(bv));
    eo = 1'b0;
    er = '0;
    rq = "R10";
    case (o)
      0: begin s = sa + sb; er = av + bv; rq = "R1";
           eo = (s > 127) || (s < -128); end
      1: begin er = av + bv; rq = "R3"; end
      2: begin s = sa - sb; er = av - bv; rq = "R2";
           eo = (s > 127) || (s < -128); end
      3: begin er = av - bv; rq = "R3"; end
      4: begin er = av & bv; rq = "R4"; end
      5: begin er = av | bv; rq = "R4"; end
      6: begin er = av ^ bv; rq = "R4"; end
      7: begin er = ~(av | bv); rq = "R4"; end
      8: begin er = av << sh; rq = "R5"; end
      9: begin er = shr(av, sh, 1'b0); rq = "R5"; end
      10: begin er = shr(av, sh, 1'b1); rq = "R5"; end
      11: begin er = av << (bv % W); rq = "R6"; end
      12: begin er = shr(av, int'(bv % W), 1'b0); rq = "R6"; end
      13: begin er = shr(av, int'(bv % W), 1'b1); rq = "R6"; end
      14: begin er = (sa < sb) ? 1 : 0; rq = "R7"; end
      15: begin er = (av < bv) ? 1 : 0; rq = "R8"; end
      16: begin er = {bv[HW-1:0], {HW{1'b0}}}; rq = "R9"; end
      default: begin er = '0; rq = "R10"; end
    endcase
    check(rq, er, eo);
    #1;
  endtask

  initial begin
    op = 5'd31; a = '0; b = '0; shamt = '0;
    #5;
    // reset-state style check: idle inputs give zero, no flag (R10)
    check("R10", '0, 1'b0);
    #20 rst_n = 1'b1;

    // R1 R2 R3 R4 R6 R7 R8 R9: every operand pair
    for (int o = 0; o <= 16; o++) begin
      if (o >= 8 && o <= 10) continue;
      for (int ai = 0; ai < 256; ai++)
        for (int bi = 0; bi < 256; bi++)
          apply_and_check(o, ai[W-1:0], bi[W-1:0], (ai + bi) % W);
    end
    // R5: constant shifts, all values and counts, B varied to show it is unused
    for (int o = 8; o <= 10; o++)
      for (int ai = 0; ai < 256; ai++)
        for (int sh = 0; sh < W; sh++)
          apply_and_check(o, ai[W-1:0], 8'(ai * 7 + sh), sh);
    // R10: unused codes
    for (int o = 17; o < 32; o++)
      for (int ai = 0; ai < 256; ai++)
        apply_and_check(o, ai[W-1:0], 8'(ai ^ 8'h5A), ai % W);
    // R2: overflow still leaves the wrapped difference on the result
    apply_and_check(2, 8'h80, 8'h01, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule